// File: doc/BRIEF.md
# Multi-channel comparator sampling sequencer

This block is the digital controller that lets one analog comparator serve up to four input channels in turn. For each step of a sequence it sets a channel select and a reference select toward the analog front end. It then captures the single comparator result bit on a chosen edge of the sampling clock and stores it in a per-channel output latch. Each channel can be compared against one or two references, and every reference counts as its own step.

Sequences start from a power-up input. That input works either as a one-shot edge trigger or as a level that keeps sequences running back to back. Results reach the outputs either all together at the end of the sequence or one at a time as each step is captured. A restart input sends a running sequence back to channel 0 and clears the latches of the channels selected for clearing.

A data-ready pulse marks the end of every sequence. When exactly one channel with one reference is configured, the sequencer stands still and the comparator drives channel 0 directly.

Everything runs on the base clock `clk`. The divided sampling clock `samp_clk` arrives as a data input that changes synchronously to `clk`. An edge of `samp_clk` takes effect at the first `clk` edge that sees the new level.

Top module: `cmpseq_top`

## Requirements
- R1: Steps run through the channels in ascending order, from channel 0 up to the channel number given on `cfg_top_ch`. A value N on `cfg_top_ch` makes channels 0 to N active. `ch_sel` shows the channel of the current step.
- R2: A channel whose `cfg_two_ref` bit is set takes two steps: first with `ref_sel`=0, then with `ref_sel`=1. Otherwise it takes one step with `ref_sel`=0. The result of channel c with reference r is stored in bit 2*c+r of `res_out`.
- R3: With `cfg_level`=0, a rising edge of `pup` seen while idle arms the block. The next advance edge of `samp_clk` starts exactly one sequence, and the block is idle again after its last step. Rising edges during a run are ignored.
- R4: With `cfg_level`=1, an advance edge while `pup` is high starts a sequence, and sequences repeat back to back while `pup` is high. Once `pup` is low, the sequence in progress finishes and the block goes idle.
- R5: With `cfg_stagger`=0, results are collected in a shadow latch. `res_out` changes only when the last step is captured, and then all bits change together. A restart clear is the only other change.
- R6: With `cfg_stagger`=1, the bit for each step changes in the same `clk` cycle in which that step is captured.
- R7: With `cfg_cap_neg`=0, results are captured on rising edges of `samp_clk` and steps advance on falling edges. With `cfg_cap_neg`=1 the two roles swap.
- R8: When `restart` is high during a run, the sequence returns to channel 0, reference 0. In the same cycle, both result bits of every channel whose `cfg_clr_en` bit is set are cleared, in the output and in the shadow.
- R9: `data_ready` is high for exactly one `clk` cycle, the cycle after the last step of a sequence is captured.
- R10: When `cfg_top_ch`=0 and `cfg_two_ref[0]`=0, the sequencer stays idle. `res_out[0]` equals `pup` AND `cmp_in` combinationally, and the other bits are 0.
- R11: While `pup` stays low and no run is in progress, no sequence starts, the selects stay at channel 0, reference 0, and `data_ready` stays low.
- R12: A step is left only after its result has been captured. After a restart, channel 0 is captured before the sequence moves on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_clk | input | 1 | Divided sampling clock, synchronous to clk |
| pup | input | 1 | Power-up / run trigger |
| cmp_in | input | 1 | Comparator result from the analog front end |
| restart | input | 1 | Restart sequence and clear selected latches |
| cfg_top_ch | input | 2 | Highest active channel |
| cfg_two_ref | input | 4 | Per-channel second-reference enable |
| cfg_level | input | 1 | 1 = level trigger, 0 = edge trigger |
| cfg_stagger | input | 1 | 1 = staggered output, 0 = simultaneous |
| cfg_cap_neg | input | 1 | 1 = capture on falling sampling edge |
| cfg_clr_en | input | 4 | Per-channel clear-on-restart enable |
| ch_sel | output | 2 | Channel select to the front end |
| ref_sel | output | 1 | Reference select to the front end |
| res_out | output | 8 | Latched results, bit 2*channel+reference |
| data_ready | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The assertions rely on the configuration inputs staying constant while a sequence runs, and on `samp_clk` holding each level for at least one `clk` cycle so that capture and advance edges alternate. The stimulus meets both conditions. It changes configuration only after dropping `pup` and waiting well beyond a full sequence. It toggles `samp_clk` every three `clk` cycles, always a little after the rising clock edge. `restart` pulses and comparator values are driven at that same offset, so their timing against the sampling edges varies freely without breaking either condition.

// File: rtl/cmpseq_pkg.sv
package cmpseq_pkg;
  parameter int unsigned CS_CHANNELS = 4;
  localparam int unsigned CS_CH_W  = (CS_CHANNELS > 1) ? $clog2(CS_CHANNELS) : 1;
  localparam int unsigned CS_IDX_W = CS_CH_W + 1;
  localparam int unsigned CS_OUT_W = 2 * CS_CHANNELS;

  typedef logic [CS_CH_W-1:0]  ch_t;
  typedef logic [CS_IDX_W-1:0] idx_t;
  typedef struct packed { ch_t ch; logic rf; } step_t;
  typedef enum logic { ST_IDLE = 1'b0, ST_RUN = 1'b1 } seq_state_e;

  // final step of a sequence: highest channel on its highest reference
  function automatic logic step_is_last(step_t s, ch_t top, logic [CS_CHANNELS-1:0] two);
    return (s.ch == top) && (s.rf || !two[s.ch]);
  endfunction

  function automatic step_t step_next(step_t s, logic [CS_CHANNELS-1:0] two);
    step_t n;
    if (!s.rf && two[s.ch]) begin
      n.ch = s.ch;
      n.rf = 1'b1;
    end else begin
      n.ch = s.ch + 1'b1;
      n.rf = 1'b0;
    end
    return n;
  endfunction

  function automatic idx_t bit_of(step_t s);
    return {s.ch, s.rf};
  endfunction

  function automatic logic [CS_OUT_W-1:0] clear_mask(logic [CS_CHANNELS-1:0] en);
    logic [CS_OUT_W-1:0] m;
    for (int i = 0; i < int'(CS_CHANNELS); i++) begin
      m[2*i]   = en[i];
      m[2*i+1] = en[i];
    end
    return m;
  endfunction
endpackage

// File: rtl/cmpseq_trigger.sv
module cmpseq_trigger (
  input  logic clk,
  input  logic rst_n,
  input  logic pup,
  input  logic level_mode,
  input  logic idle,
  input  logic take,
  output logic start_req
);
  logic pup_q, armed, pup_rise;

  assign pup_rise  = pup & ~pup_q;
  assign start_req = level_mode ? pup : armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pup_q <= 1'b0;
      armed <= 1'b0;
    end else begin
      pup_q <= pup;
      if (take || level_mode)   armed <= 1'b0;
      else if (idle && pup_rise) armed <= 1'b1;
    end
  end

  // a one-shot arm is consumed by the start it causes (R3)
  assert_arm_consumed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !level_mode) |=> !armed);
endmodule

// File: rtl/cmpseq_stepper.sv
module cmpseq_stepper
  import cmpseq_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   enable,
  input  logic                   samp_clk,
  input  logic                   cap_neg,
  input  logic                   level_mode,
  input  logic                   pup,
  input  logic                   start_req,
  input  logic                   restart,
  input  ch_t                    top_ch,
  input  logic [CS_CHANNELS-1:0] two_ref,
  output step_t                  step,
  output logic                   running,
  output logic                   cap_fire,
  output logic                   cap_last,
  output logic                   clr_fire,
  output logic                   take,
  output logic                   drdy
);
  seq_state_e state;
  logic sclk_q, done;
  logic s_rise, s_fall, cap_ev, adv_ev, adv_fire, last;

  assign s_rise   = samp_clk & ~sclk_q;
  assign s_fall   = ~samp_clk & sclk_q;
  assign cap_ev   = cap_neg ? s_fall : s_rise;
  assign adv_ev   = cap_neg ? s_rise : s_fall;
  assign running  = (state == ST_RUN);
  assign last     = step_is_last(step, top_ch, two_ref);
  assign clr_fire = running & enable & restart;
  assign cap_fire = running & enable & cap_ev & ~done & ~restart;
  assign cap_last = cap_fire & last;
  assign adv_fire = running & enable & adv_ev & done & ~restart;
  assign take     = ~running & enable & adv_ev & start_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      step   <= '0;
      done   <= 1'b0;
      sclk_q <= 1'b0;
      drdy   <= 1'b0;
    end else begin
      sclk_q <= samp_clk;
      drdy   <= cap_last;
      if (!enable) begin
        state <= ST_IDLE;
        step  <= '0;
        done  <= 1'b0;
      end else if (clr_fire) begin
        step <= '0;
        done <= 1'b0;
      end else if (cap_fire) begin
        done <= 1'b1;
      end else if (adv_fire) begin
        done <= 1'b0;
        if (!last) step <= step_next(step, two_ref);
        else begin
          step  <= '0;
          state <= (level_mode && pup) ? ST_RUN : ST_IDLE;
        end
      end else if (take) begin
        state <= ST_RUN;
        step  <= '0;
        done  <= 1'b0;
      end
    end
  end

  assert_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && step.ch != $past(step.ch))
      |-> (step.ch == ch_t'($past(step.ch) + 1'b1) || step.ch == '0));
  assert_active_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> step.ch <= top_ch);
  assert_ref_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (running && step.rf) |-> two_ref[step.ch]);
  assert_idle_home_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (step == '0));
  assert_drdy_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    drdy |=> !drdy);
  assert_capture_first_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && step != $past(step) && !$past(clr_fire)) |-> $past(done));
endmodule

// File: rtl/cmpseq_latch.sv
module cmpseq_latch
  import cmpseq_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   stagger,
  input  logic                   cap_fire,
  input  logic                   cap_last,
  input  logic                   clr_fire,
  input  step_t                  step,
  input  logic                   cmp,
  input  logic [CS_CHANNELS-1:0] clr_en,
  output logic [CS_OUT_W-1:0]    res
);
  logic [CS_OUT_W-1:0] shadow, merged, mask;

  assign mask = clear_mask(clr_en);

  always_comb begin
    merged = shadow;
    merged[bit_of(step)] = cmp;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow <= '0;
      res    <= '0;
    end else if (clr_fire) begin
      shadow <= shadow & ~mask;
      res    <= res & ~mask;
    end else if (cap_fire) begin
      shadow <= merged;
      if (stagger)       res[bit_of(step)] <= cmp;
      else if (cap_last) res <= merged;
    end
  end

  assert_restart_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fire |=> ((res & $past(mask)) == '0));
  assert_simul_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!stagger && !cap_last && !clr_fire) |=> $stable(res));
  assert_stagger_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stagger && cap_fire) |=> (res[bit_of($past(step))] == $past(cmp)));
endmodule

// File: rtl/cmpseq_top.sv
module cmpseq_top
  import cmpseq_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   samp_clk,
  input  logic                   pup,
  input  logic                   cmp_in,
  input  logic                   restart,
  input  logic [CS_CH_W-1:0]     cfg_top_ch,
  input  logic [CS_CHANNELS-1:0] cfg_two_ref,
  input  logic                   cfg_level,
  input  logic                   cfg_stagger,
  input  logic                   cfg_cap_neg,
  input  logic [CS_CHANNELS-1:0] cfg_clr_en,
  output logic [CS_CH_W-1:0]     ch_sel,
  output logic                   ref_sel,
  output logic [CS_OUT_W-1:0]    res_out,
  output logic                   data_ready
);
  step_t               step;
  logic                bypass, running, start_req, take;
  logic                cap_fire, cap_last, clr_fire;
  logic [CS_OUT_W-1:0] latched;

  assign bypass = (cfg_top_ch == '0) && !cfg_two_ref[0];

  cmpseq_trigger u_trig (
    .clk(clk), .rst_n(rst_n), .pup(pup), .level_mode(cfg_level),
    .idle(~running), .take(take), .start_req(start_req)
  );

  cmpseq_stepper u_step (
    .clk(clk), .rst_n(rst_n), .enable(~bypass), .samp_clk(samp_clk),
    .cap_neg(cfg_cap_neg), .level_mode(cfg_level), .pup(pup),
    .start_req(start_req), .restart(restart), .top_ch(cfg_top_ch),
    .two_ref(cfg_two_ref), .step(step), .running(running),
    .cap_fire(cap_fire), .cap_last(cap_last), .clr_fire(clr_fire),
    .take(take), .drdy(data_ready)
  );

  cmpseq_latch u_latch (
    .clk(clk), .rst_n(rst_n), .stagger(cfg_stagger), .cap_fire(cap_fire),
    .cap_last(cap_last), .clr_fire(clr_fire), .step(step), .cmp(cmp_in),
    .clr_en(cfg_clr_en), .res(latched)
  );

  assign ch_sel  = step.ch;
  assign ref_sel = step.rf;
  assign res_out = bypass ? {{(CS_OUT_W-1){1'b0}}, pup & cmp_in} : latched;

  assert_bypass_parked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && $past(bypass)) |-> (!running && !data_ready));
endmodule

// File: tb/test_cmpseq_top.sv
`timescale 1ns/1ps
module test_cmpseq_top;
  import cmpseq_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, samp_clk, pup, cmp_in, restart;
  logic cfg_level, cfg_stagger, cfg_cap_neg;
  logic [CS_CH_W-1:0]     cfg_top;
  logic [CS_CHANNELS-1:0] cfg_two, cfg_clr;
  logic [CS_CH_W-1:0]     ch_sel;
  logic                   ref_sel, data_ready;
  logic [CS_OUT_W-1:0]    res_out;

  cmpseq_top i_cmpseq_top (
    .clk(clk), .rst_n(rst_n), .samp_clk(samp_clk), .pup(pup), .cmp_in(cmp_in),
    .restart(restart), .cfg_top_ch(cfg_top), .cfg_two_ref(cfg_two),
    .cfg_level(cfg_level), .cfg_stagger(cfg_stagger), .cfg_cap_neg(cfg_cap_neg),
    .cfg_clr_en(cfg_clr), .ch_sel(ch_sel), .ref_sel(ref_sel),
    .res_out(res_out), .data_ready(data_ready)
  );

  int n_checks = 0;
  int n_fail = 0;
  int n_drdy = 0;
  bit checking = 0;
  string cur_tag = "R1";

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // ---------------- reference model ----------------
  int lc[2*CS_CHANNELS];
  int lr[2*CS_CHANNELS];
  int ln;
  bit m_run, m_done, m_armed, m_pupp, m_sclkp, m_drdy;
  int m_idx;
  logic [CS_OUT_W-1:0] m_res, m_shadow;

  function automatic void build_list();
    ln = 0;
    for (int c = 0; c <= int'(cfg_top); c++) begin
      lc[ln] = c; lr[ln] = 0; ln++;
      if (cfg_two[c]) begin lc[ln] = c; lr[ln] = 1; ln++; end
    end
  endfunction

  function automatic bit is_bypass();
    return (cfg_top == 0) && !cfg_two[0];
  endfunction

  always @(posedge clk) begin
    bit rise, fall, cap, adv, bp, start, lst, take, nd;
    int bi;
    build_list();
    if (!rst_n) begin
      m_run = 0; m_done = 0; m_armed = 0; m_pupp = 0; m_sclkp = 0;
      m_drdy = 0; m_idx = 0; m_res = '0; m_shadow = '0;
    end else begin
      rise  = samp_clk && !m_sclkp;
      fall  = !samp_clk && m_sclkp;
      cap   = cfg_cap_neg ? fall : rise;
      adv   = cfg_cap_neg ? rise : fall;
      bp    = is_bypass();
      lst   = (m_idx == ln - 1);
      start = cfg_level ? pup : m_armed;
      take  = !m_run && !bp && adv && start;
      nd    = 0;
      if (take || cfg_level) m_armed = 0;
      else if (!m_run && pup && !m_pupp) m_armed = 1;
      if (bp) begin
        m_run = 0; m_idx = 0; m_done = 0;
      end else if (m_run && restart) begin
        m_idx = 0; m_done = 0;
        for (int c = 0; c < int'(CS_CHANNELS); c++)
          if (cfg_clr[c]) begin
            m_res[2*c] = 0; m_res[2*c+1] = 0;
            m_shadow[2*c] = 0; m_shadow[2*c+1] = 0;
          end
      end else if (m_run && cap && !m_done) begin
        bi = 2*lc[m_idx] + lr[m_idx];
        m_shadow[bi] = cmp_in;
        if (cfg_stagger) m_res[bi] = cmp_in;
        else if (lst) m_res = m_shadow;
        m_done = 1;
        nd = lst;
      end else if (m_run && adv && m_done) begin
        m_done = 0;
        if (!lst) m_idx++;
        else begin
          m_idx = 0;
          m_run = cfg_level && pup;
        end
      end else if (take) begin
        m_run = 1; m_idx = 0; m_done = 0;
      end
      m_drdy = nd;
    end
    m_pupp  = pup;
    m_sclkp = samp_clk;
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    logic [CS_OUT_W-1:0] exp_res;
    if (rst_n && checking) begin
      exp_res = is_bypass() ? {{(CS_OUT_W-1){1'b0}}, pup & cmp_in} : m_res;
      check("R1/R2 channel select", 32'(ch_sel), 32'(lc[m_idx]));
      check("R2 reference select", 32'(ref_sel), 32'(lr[m_idx]));
      check({cur_tag, " results"}, 32'(res_out), 32'(exp_res));
      check("R9 data_ready", 32'(data_ready), 32'(m_drdy));
      if (data_ready) n_drdy++;
    end
  end

  // sampling clock and comparator stimulus
  initial begin
    int k;
    k = 0;
    samp_clk = 1'b0;
    cmp_in = 1'b0;
    forever begin
      @(posedge clk); #2;
      cmp_in = 1'($urandom_range(1, 0));
      k++;
      if (k == 3) begin k = 0; samp_clk = ~samp_clk; end
    end
  end

  task automatic cyc(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic pulse_restart();
    restart = 1'b1; cyc(1); restart = 1'b0;
  endtask

  task automatic set_cfg(logic [CS_CH_W-1:0] top, logic [CS_CHANNELS-1:0] two,
                         logic lvl, logic stg, logic neg, logic [CS_CHANNELS-1:0] clr);
    pup = 1'b0;
    cyc(90);
    cfg_top = top; cfg_two = two; cfg_level = lvl;
    cfg_stagger = stg; cfg_cap_neg = neg; cfg_clr = clr;
    cyc(2);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_up();
  end

  initial begin
    rst_n = 1'b0; pup = 1'b0; restart = 1'b0;
    cfg_top = 2'd3; cfg_two = 4'b0101; cfg_level = 1'b0;
    cfg_stagger = 1'b0; cfg_cap_neg = 1'b0; cfg_clr = 4'b0000;
    cyc(4);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state: home selects, cleared results, no pulse (R1, R9, R11)
    check("R1 reset ch_sel", 32'(ch_sel), 32'd0);
    check("R11 reset ref_sel", 32'(ref_sel), 32'd0);
    check("R5 reset res_out", 32'(res_out), 32'd0);
    check("R9 reset data_ready", 32'(data_ready), 32'd0);
    checking = 1;
    cyc(1);

    // R3 + R5: edge trigger, simultaneous, channels 0..3 with two refs on 0 and 2
    cur_tag = "R3/R5";
    n_drdy = 0;
    pup = 1'b1; cyc(5); pup = 1'b0;
    cyc(80);
    check("R3 one sequence per rising edge", 32'(n_drdy), 32'd1);
    pup = 1'b1; cyc(40); pup = 1'b0; cyc(60);

    // R4 + R6 + R7: level trigger, staggered, falling-edge capture
    cur_tag = "R4/R6/R7";
    set_cfg(2'd2, 4'b1010, 1'b1, 1'b1, 1'b1, 4'b0000);
    n_drdy = 0;
    pup = 1'b1; cyc(100); pup = 1'b0;
    cyc(60);
    check("R4 repeated sequences while high", 32'(n_drdy >= 3), 32'd1);

    // R11: level trigger with pup held low
    cur_tag = "R11";
    n_drdy = 0;
    cyc(60);
    check("R11 no pulse while off", 32'(n_drdy), 32'd0);
    check("R11 selects parked", 32'({ch_sel, ref_sel}), 32'd0);

    // R8 + R12: restart with selective clearing, simultaneous then staggered
    cur_tag = "R8/R12";
    set_cfg(2'd3, 4'b1111, 1'b1, 1'b0, 1'b0, 4'b0101);
    pup = 1'b1;
    for (int i = 0; i < 8; i++) begin
      cyc(17 + 5*i);
      pulse_restart();
    end
    cyc(60); pup = 1'b0; cyc(20);
    set_cfg(2'd3, 4'b0110, 1'b1, 1'b1, 1'b1, 4'b1010);
    pup = 1'b1;
    for (int i = 0; i < 8; i++) begin
      cyc(11 + 7*i);
      pulse_restart();
    end
    cyc(50); pup = 1'b0;

    // R2: single channel with two references is not bypassed
    cur_tag = "R2";
    set_cfg(2'd0, 4'b0001, 1'b0, 1'b0, 1'b0, 4'b0000);
    n_drdy = 0;
    pup = 1'b1; cyc(3); pup = 1'b0; cyc(40);
    check("R2 two-step single channel completes", 32'(n_drdy), 32'd1);

    // R10: bypass, comparator straight to channel 0 output
    cur_tag = "R10";
    set_cfg(2'd0, 4'b0000, 1'b1, 1'b0, 1'b0, 4'b0000);
    n_drdy = 0;
    pup = 1'b1; cyc(30);
    @(negedge clk);
    check("R10 bypass passthrough", 32'(res_out), 32'(cmp_in));
    cyc(1);
    pup = 1'b0; cyc(20);
    check("R10 no data_ready in bypass", 32'(n_drdy), 32'd0);

    // R1: back to a sequenced setup, edge mode, rising capture
    cur_tag = "R1/R6";
    set_cfg(2'd3, 4'b0000, 1'b0, 1'b1, 1'b0, 4'b1111);
    pup = 1'b1; cyc(2); pup = 1'b0; cyc(60);

    checking = 0;
    finish_up();
  end
endmodule